// File: doc/BRIEF.md
# DDR Command Timing Monitor

This block watches the command bus that a DDR SDRAM controller drives toward a four-bank device. It samples the bus on each rising clock edge and keeps a running age, in clock cycles, for every event that a later command must respect. It also records which banks hold an open row. A command issued too early, an access to the wrong bank state, or a row held open too long raises a one-cycle violation pulse. A 4-bit code comes with the pulse and names the rule that failed.

All limits are parameters in clock cycles. The defaults suit a 5 ns clock:

| Limit | Default (cycles) |
|---|---|
| activate to access | 3 |
| precharge period | 3 |
| minimum row open time | 8 |
| same-bank activate to activate | 11 |
| cross-bank activate spacing | 2 |
| mode load gap | 3 |
| refresh period | 14 |
| write recovery | 3 |
| write-to-read delay | 1 |
| maximum row open time | 14000 |

Other fixed assumptions:
- A burst occupies 2 clocks.
- Write data starts 1 clock after the write command.

The monitor only observes the bus and never drives it. Data-path and refresh-scheduling checks are not its job.

Top module: `ddr_cmd_timing_mon`

## Requirements
- R1: A command is decoded only on a rising edge where `cmd_sel_n` is 0. The opcode {`cmd_row_n`,`cmd_col_n`,`cmd_wr_n`} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh and 000 mode load. Opcode 111 (NOP) and any deselected edge change no state.
- R2: An edge whose command breaks a rule causes `viol`=1 and `viol_code` to show that rule after that edge. Otherwise both are 0, including straight after reset. "Spacing n" means the two commands are n edges apart. When several rules fail, the lowest code is reported.
- R3: Any decoded command, including opcode 110, issued at spacing below the mode load gap after a mode load gives code 1.
- R4: An activate or refresh at spacing below the refresh period after a refresh gives code 2.
- R5: Code 3 is reported for any of these:
  - a read or write to a bank without an open row;
  - an activate to a bank whose row is open;
  - a refresh while any bank is open.
- R6: A read or write to an open bank at spacing below the activate-to-access limit after that bank's activate gives code 4.
- R7: An activate to a bank, or a refresh, gives code 5 if the precharge recovery of that bank (or of any bank, for a refresh) has not elapsed. Recovery is counted from the closing command and lasts:
  - the precharge period after an explicit precharge;
  - 2 clocks plus the precharge period after a read with auto-precharge;
  - 6 clocks (1 + 2 + write recovery) plus the precharge period after a write with auto-precharge.
- R8: Code 6 is reported when a row would close too early:
  - a precharge closes an open bank sooner than the minimum row open time after its activate;
  - a read with `auto_pre`=1 where activate age + 2 is below that minimum;
  - a write with `auto_pre`=1 where activate age + 6 is below that minimum.
- R9: An activate to a bank, or a refresh, at spacing below the same-bank activate-to-activate limit after an activate of that bank (or of any bank, for a refresh) gives code 7.
- R10: An activate at spacing below the cross-bank spacing after an activate of any other bank gives code 8.
- R11: A precharge that closes a bank at spacing below 6 after a write to that open bank gives code 9.
- R12: A read at spacing below 4 after the last write to any open bank gives code 10.
- R13: A bank whose row is still open exactly max-open-time + 1 cycles after its activate gives a code 11 pulse, with no command needed.
- R14: A precharge with `auto_pre`=1 closes every open bank and checks each one against R8 and R11. A precharge that reaches a closed bank leaves that bank's recovery timing untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_sel_n | input | 1 | Device select, active low |
| cmd_row_n | input | 1 | Row strobe, active low |
| cmd_col_n | input | 1 | Column strobe, active low |
| cmd_wr_n | input | 1 | Write enable, active low |
| bank | input | BA_W | Bank address |
| auto_pre | input | 1 | Address bit 10: all-bank precharge or auto-precharge |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Rule that failed, 0 when none |

## Verification
The hardest situation to reach from the ports is the maximum row open time. It needs one bank held open for more than fourteen thousand edges with no other command touching it. A directed run opens a bank, idles the bus for the exact count, and expects the code 11 pulse on one specific edge.

Auto-precharge recovery is the next hardest, because only its extended length tells it apart from a plain precharge. Directed sequences re-activate the bank between the plain precharge period and the extended one.

Random traffic fills the rest. It is weighted toward NOPs so that many commands fall just inside and just outside each window. A bench model built from timestamps predicts the code on every edge.

// File: rtl/ddr_cmd_timing_mon.sv
module ddr_cmd_timing_mon #(
  parameter int BA_W      = 2,
  parameter int CW        = 16,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 8,
  parameter int T_RC      = 11,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 3,
  parameter int T_RFC     = 14,
  parameter int T_WR      = 3,
  parameter int T_WTR     = 1,
  parameter int BURST_CK  = 2,
  parameter int T_RAS_MAX = 14000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_sel_n,
  input  logic            cmd_row_n,
  input  logic            cmd_col_n,
  input  logic            cmd_wr_n,
  input  logic [BA_W-1:0] bank,
  input  logic            auto_pre,
  output logic            viol,
  output logic [3:0]      viol_code
);
  timeunit 1ns; timeprecision 1ps;

  localparam int NB  = 1 << BA_W;
  localparam int CWX = CW + 1;
  typedef logic [CW-1:0] age_t;
  localparam age_t AGE_MAX = '1;
  localparam age_t ONE     = age_t'(1);
  localparam age_t L_RCD   = age_t'(T_RCD);
  localparam age_t L_RP    = age_t'(T_RP);
  localparam age_t L_RAS   = age_t'(T_RAS);
  localparam age_t L_RC    = age_t'(T_RC);
  localparam age_t L_RRD   = age_t'(T_RRD);
  localparam age_t L_MRD   = age_t'(T_MRD);
  localparam age_t L_RFC   = age_t'(T_RFC);
  localparam age_t L_WRG   = age_t'(1 + BURST_CK + T_WR);
  localparam age_t L_WTRG  = age_t'(1 + BURST_CK + T_WTR);
  localparam age_t L_RPRD  = age_t'(BURST_CK + T_RP);
  localparam age_t L_RPWR  = age_t'(1 + BURST_CK + T_WR + T_RP);
  localparam age_t L_HIT   = age_t'(T_RAS_MAX + 1);
  localparam logic [CW:0] X_RAS = CWX'(T_RAS);
  localparam logic [CW:0] X_RD  = CWX'(BURST_CK);
  localparam logic [CW:0] X_WR  = CWX'(1 + BURST_CK + T_WR);

  function automatic age_t bump(age_t a);
    return (a == AGE_MAX) ? a : a + ONE;
  endfunction

  wire [2:0] op     = {cmd_row_n, cmd_col_n, cmd_wr_n};
  wire       live   = !cmd_sel_n && op != 3'b111;
  wire       is_act = !cmd_sel_n && op == 3'b011;
  wire       is_rd  = !cmd_sel_n && op == 3'b101;
  wire       is_wr  = !cmd_sel_n && op == 3'b100;
  wire       is_pre = !cmd_sel_n && op == 3'b010;
  wire       is_ref = !cmd_sel_n && op == 3'b001;
  wire       is_lmr = !cmd_sel_n && op == 3'b000;
  wire       is_rw  = is_rd || is_wr;

  logic [NB-1:0] open_q;
  age_t act_age [NB];
  age_t pre_age [NB];
  age_t rp_need [NB];
  age_t wr_age  [NB];
  age_t mrd_age, rfc_age, wtr_age;

  logic [11:1] hit;
  logic [3:0]  code_n;

  always_comb begin
    hit = '0;
    hit[1]  = live && mrd_age < L_MRD;
    hit[2]  = (is_act || is_ref) && rfc_age < L_RFC;
    hit[3]  = (is_rw && !open_q[bank]) || (is_act && open_q[bank]) || (is_ref && |open_q);
    hit[4]  = is_rw && open_q[bank] && act_age[bank] < L_RCD;
    hit[10] = is_rd && wtr_age < L_WTRG;
    for (int b = 0; b < NB; b++) begin
      if ((is_act && bank == BA_W'(b)) || is_ref) begin
        if (pre_age[b] < rp_need[b]) hit[5] = 1'b1;
        if (act_age[b] < L_RC)       hit[7] = 1'b1;
      end
      if (is_act && bank != BA_W'(b) && act_age[b] < L_RRD) hit[8] = 1'b1;
      if (is_pre && open_q[b] && (auto_pre || bank == BA_W'(b))) begin
        if (act_age[b] < L_RAS) hit[6] = 1'b1;
        if (wr_age[b] < L_WRG)  hit[9] = 1'b1;
      end
      if (is_rw && auto_pre && open_q[b] && bank == BA_W'(b) &&
          ({1'b0, act_age[b]} + (is_rd ? X_RD : X_WR)) < X_RAS) hit[6] = 1'b1;
      if (open_q[b] && act_age[b] == L_HIT) hit[11] = 1'b1;
    end
    code_n = 4'd0;
    for (int k = 11; k >= 1; k--)
      if (hit[k]) code_n = 4'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= '0;
      mrd_age   <= AGE_MAX;
      rfc_age   <= AGE_MAX;
      wtr_age   <= AGE_MAX;
      viol      <= 1'b0;
      viol_code <= 4'd0;
      for (int b = 0; b < NB; b++) begin
        act_age[b] <= AGE_MAX;
        pre_age[b] <= AGE_MAX;
        wr_age[b]  <= AGE_MAX;
        rp_need[b] <= '0;
      end
    end else begin
      viol      <= |hit;
      viol_code <= code_n;
      mrd_age   <= is_lmr ? ONE : bump(mrd_age);
      rfc_age   <= is_ref ? ONE : bump(rfc_age);
      wtr_age   <= (is_wr && open_q[bank]) ? ONE : bump(wtr_age);
      for (int b = 0; b < NB; b++) begin
        act_age[b] <= (is_act && bank == BA_W'(b)) ? ONE : bump(act_age[b]);
        wr_age[b]  <= (is_wr && open_q[b] && bank == BA_W'(b)) ? ONE : bump(wr_age[b]);
        pre_age[b] <= bump(pre_age[b]);
        if (is_act && bank == BA_W'(b)) begin
          open_q[b] <= 1'b1;
        end else if (is_pre && open_q[b] && (auto_pre || bank == BA_W'(b))) begin
          open_q[b]  <= 1'b0;
          pre_age[b] <= ONE;
          rp_need[b] <= L_RP;
        end else if (is_rw && auto_pre && open_q[b] && bank == BA_W'(b)) begin
          open_q[b]  <= 1'b0;
          pre_age[b] <= ONE;
          rp_need[b] <= is_rd ? L_RPRD : L_RPWR;
        end
      end
    end
  end

  // R5
  access_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && !open_q[bank]) |=> viol);

  // R14
  pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && auto_pre) |=> (open_q == '0));

  // R2
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_code != 4'd0 && viol_code <= 4'd11));

  // R3
  mode_gap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mrd_age < L_MRD) |=> (viol && viol_code == 4'd1));

  // R1
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> open_q[$past(bank)]);
endmodule

// File: tb/sim_ddr_cmd_timing_mon.sv
module sim_ddr_cmd_timing_mon;
  timeunit 1ns; timeprecision 1ps;

  localparam bit [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010,
                       REF = 3'b001, LMR = 3'b000, NOP = 3'b111, BST = 3'b110;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1, row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1;
  logic [1:0] bank = 2'd0;
  logic       ap = 1'b0;
  logic       viol;
  logic [3:0] viol_code;

  ddr_cmd_timing_mon u0 (
    .clk(clk), .rst_n(rst_n), .cmd_sel_n(sel_n), .cmd_row_n(row_n),
    .cmd_col_n(col_n), .cmd_wr_n(wr_n), .bank(bank), .auto_pre(ap),
    .viol(viol), .viol_code(viol_code));

  int checks = 0, errs = 0;
  int n = 0;
  int t_act[4], t_pre[4], need_rp[4], t_wr[4];
  bit open_m[4];
  int t_wany = -100000, t_lmr = -100000, t_ref = -100000;

  task automatic model_step(input bit cs, input bit [2:0] op, input int b,
                            input bit a, output int code);
    bit act, rd, wr, pre, rf, lmr, live;
    bit [11:0] h;
    h = '0;
    live = !cs && op != NOP;
    act = !cs && op == ACT; rd = !cs && op == RD; wr = !cs && op == WR;
    pre = !cs && op == PRE; rf = !cs && op == REF; lmr = !cs && op == LMR;
    if (live && n - t_lmr < 3) h[1] = 1;
    if ((act || rf) && n - t_ref < 14) h[2] = 1;
    if (((rd || wr) && !open_m[b]) || (act && open_m[b])) h[3] = 1;
    if ((rd || wr) && open_m[b] && n - t_act[b] < 3) h[4] = 1;
    if (rd && n - t_wany < 4) h[10] = 1;
    for (int j = 0; j < 4; j++) begin
      int age_a;
      age_a = n - t_act[j];
      if (rf && open_m[j]) h[3] = 1;
      if ((act && j == b) || rf) begin
        if (n - t_pre[j] < need_rp[j]) h[5] = 1;
        if (age_a < 11) h[7] = 1;
      end
      if (act && j != b && age_a < 2) h[8] = 1;
      if (pre && open_m[j] && (a || j == b)) begin
        if (age_a < 8) h[6] = 1;
        if (n - t_wr[j] < 6) h[9] = 1;
      end
      if ((rd || wr) && a && j == b && open_m[j] && age_a + (rd ? 2 : 6) < 8) h[6] = 1;
      if (open_m[j] && age_a == 14001) h[11] = 1;
    end
    code = 0;
    for (int k = 11; k >= 1; k--) if (h[k]) code = k;
    if (lmr) t_lmr = n;
    if (rf) t_ref = n;
    if (wr && open_m[b]) begin t_wany = n; t_wr[b] = n; end
    for (int j = 0; j < 4; j++) begin
      if (act && j == b) begin
        t_act[j] = n; open_m[j] = 1;
      end else if (pre && open_m[j] && (a || j == b)) begin
        open_m[j] = 0; t_pre[j] = n; need_rp[j] = 3;
      end else if ((rd || wr) && a && j == b && open_m[j]) begin
        open_m[j] = 0; t_pre[j] = n; need_rp[j] = rd ? 5 : 9;
      end
    end
    n++;
  endtask

  task automatic step(input bit cs, input bit [2:0] op, input int b, input bit a,
                      input int hand, input string tag);
    int mc, want;
    @(negedge clk);
    sel_n = cs; {row_n, col_n, wr_n} = op; bank = 2'(b); ap = a;
    model_step(cs, op, b, a, mc);
    want = (hand >= 0) ? hand : mc;
    @(posedge clk); #1;
    checks++;
    if (viol !== (want != 0) || viol_code !== 4'(want)) begin
      errs++;
      $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d",
               tag, viol, viol_code, want != 0, want);
    end
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) step(0, NOP, 0, 0, -1, "R2 idle");
  endtask

  task automatic settle();
    step(0, PRE, 0, 1, -1, "R2 settle");
    idle(20);
  endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    for (int j = 0; j < 4; j++) begin
      t_act[j] = -100000; t_pre[j] = -100000; t_wr[j] = -100000;
      need_rp[j] = 0; open_m[j] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    checks++;
    if (viol !== 1'b0 || viol_code !== 4'd0) begin
      errs++;
      $display("FAIL R2 reset: viol=%0b code=%0d expected 0/0", viol, viol_code);
    end

    settle();
    step(1, ACT, 0, 0, 0, "R1 deselected");
    step(0, RD,  0, 0, 3, "R1 bank still closed");
    step(0, ACT, 0, 0, 0, "R1 activate");
    step(0, RD,  0, 0, 4, "R6 early read");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, RD,  0, 0, 0, "R6 read on time");
    step(0, ACT, 0, 0, 3, "R5 R2 open bank activate");
    step(0, ACT, 1, 0, 8, "R10 close activate");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, ACT, 2, 0, 0, "R10 spaced activate");
    step(0, PRE, 0, 0, 6, "R8 early precharge");
    step(0, ACT, 0, 0, 5, "R7 early reopen");
    step(0, WR,  1, 0, 0, "R11 write");
    step(0, RD,  2, 0, 10, "R12 read after write");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, RD,  2, 0, 0, "R12 read spaced");
    step(0, PRE, 1, 0, 9, "R11 write recovery");
    step(0, PRE, 0, 1, 6, "R14 all-bank tRAS");
    step(0, PRE, 3, 0, 0, "R14 closed precharge");
    step(0, ACT, 3, 0, 0, "R14 closed precharge ignored");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, WR,  3, 0, 0, "R11 write");
    idle(5);
    step(0, PRE, 3, 0, 0, "R11 recovery met");

    settle();
    step(0, ACT, 3, 0, 0, "R8 open");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, RD,  3, 1, 6, "R8 auto-precharge too soon");
    step(0, ACT, 3, 0, 5, "R7 after auto read");
    idle(10);
    step(0, RD,  3, 1, 0, "R8 auto-precharge ok");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, ACT, 3, 0, 5, "R7 read auto recovery");
    idle(10);
    step(0, WR,  3, 1, 0, "R8 write auto ok");
    idle(7);
    step(0, ACT, 3, 0, 5, "R7 write auto recovery");

    settle();
    step(0, LMR, 0, 0, 0, "R3 mode load");
    step(0, NOP, 0, 0, 0, "R3 nop allowed");
    step(0, PRE, 0, 0, 1, "R3 command too soon");
    step(0, PRE, 0, 0, 0, "R3 gap met");
    step(0, LMR, 0, 0, 0, "R3 second load");
    step(0, ACT, 1, 0, 1, "R2 lowest code wins");
    step(0, PRE, 0, 1, 1, "R2 mode over tRAS");
    idle(13);
    step(0, REF, 0, 0, 0, "R4 refresh");
    idle(4);
    step(0, REF, 0, 0, 2, "R4 refresh too soon");
    idle(13);
    step(0, ACT, 0, 0, 0, "R4 activate after refresh");
    idle(6);
    step(0, PRE, 0, 0, 6, "R8 precharge");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, NOP, 0, 0, 0, "R1 nop");
    step(0, ACT, 0, 0, 7, "R9 same-bank activate");
    step(0, BST, 0, 0, 0, "R1 burst stop");

    settle();
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit [2:0] op;
      bit cs;
      r = int'($urandom % 100);
      cs = 0;
      if      (r < 45) op = NOP;
      else if (r < 60) op = ACT;
      else if (r < 70) op = RD;
      else if (r < 80) op = WR;
      else if (r < 90) op = PRE;
      else if (r < 92) op = REF;
      else if (r < 93) op = LMR;
      else if (r < 94) op = BST;
      else begin op = 3'($urandom); cs = 1; end
      step(cs, op, int'($urandom % 4), bit'($urandom % 4 == 0), -1, "R2 random");
    end

    settle();
    step(0, ACT, 2, 0, 0, "R13 open");
    idle(14000);
    step(0, NOP, 0, 0, 11, "R13 row open too long");
    step(0, PRE, 2, 0, 0, "R13 late close");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule